// File: doc/BRIEF.md
# Two-Wire Addressed Slave Front End

This block is the bus-facing half of a two-wire serial slave that controls a pair of digitally set resistor ladders. It watches an open-drain clock and data pair with a much faster system clock. Both lines pass through a synchronizer and a small majority-vote filter. From the filtered lines the block finds start and stop conditions and frames bytes most significant bit first. It drives the acknowledge bit by enabling a pull-down on the data line, and never drives the line high.

A transaction opens with an address byte that carries no read/write bit. Its upper nibble must be the device type 0101 and its lower nibble must equal four strap inputs. The next byte is a command, which the block passes to an executor. Its opcode nibble decides the direction of any third byte. For a write, the third byte is received and handed over. For a read, the block sends a byte supplied by the executor and then reports the master's acknowledge. A stop after an accepted address raises an end-of-transaction pulse, which lets the executor start a nonvolatile write. While that write is busy, the block refuses its own address so the host can poll until it is acknowledged again.

Top module: `tw_slave_fe`

## Requirements
- R1: A start condition (filtered SDA falls while filtered SCL is high) in any state aborts the current transfer, releases SDA and restarts address reception. A stop condition (SDA rises while SCL is high) returns the block to idle with SDA released.
- R2: Clock pulses and data seen before the first start condition are ignored: no acknowledge and no output pulse.
- R3: An address byte is acknowledged only when bits 7:4 equal 0101 and bits 3:0 equal `strap_addr`. On a mismatch, the block stays silent for the rest of that transaction.
- R4: An acknowledge pulls SDA low for the whole ninth SCL clock and is released after the ninth falling edge. `sda_oe` only changes while SCL is low, and is 0 after reset.
- R5: After an accepted address, the second byte appears on `cmd_byte` with a one-cycle `cmd_valid` pulse and is acknowledged.
- R6: For a command whose bits 7:4 are neither 1001 nor 1011, the third byte appears on `data_byte` with a one-cycle `data_valid` pulse and is acknowledged. Any later byte in the same transaction is not acknowledged.
- R7: For a command whose bits 7:4 are 1001 or 1011, `rd_data` is sampled when the command's acknowledge ends and is sent MSB first. Each bit changes only after SCL falls. SDA is then released, and on the ninth rising edge `rd_done` pulses with `rd_acked`=1 if the master held SDA low, 0 otherwise.
- R8: While `nv_busy` is 1, a matching address gets no acknowledge. Once it returns to 0, the same address is acknowledged again.
- R9: `txn_end` pulses for one cycle on a stop only if an address was accepted since the last start. `cmd_valid`, `data_valid` and `txn_end` never pulse together.
- R10: A single-system-clock glitch on SCL during a bit's high phase neither adds nor loses a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed bus clock line |
| sda_i | input | 1 | Sensed bus data line (wired level) |
| sda_oe | output | 1 | 1 = pull the data line low |
| strap_addr | input | 4 | Pin-strapped low nibble of the device address |
| nv_busy | input | 1 | Nonvolatile write in progress; refuse the address |
| rd_data | input | 8 | Byte to send for a read command |
| cmd_valid | output | 1 | One-cycle pulse: command byte received |
| cmd_byte | output | 8 | Last command byte |
| data_valid | output | 1 | One-cycle pulse: write data byte received |
| data_byte | output | 8 | Last write data byte |
| rd_done | output | 1 | One-cycle pulse: master's reply to a read byte sampled |
| rd_acked | output | 1 | Master acknowledged the read byte |
| txn_end | output | 1 | One-cycle pulse: stop ending an addressed transaction |

## Verification
The address match runs through all 256 address byte values against one strap setting. This separates a wrong device-type nibble, a wrong strap comparison and a swapped nibble, and each failure shows up as a wrong acknowledge on a specific code. Further runs cover two write commands and two read commands with different data patterns and both master replies, checking the direction decode and the bit order. A busy poll, a repeated start in mid-command, clocking before any start, trailing bytes after a mismatch or after data, and SCL glitches each target one control path that the plain transfers would leave untested.

// File: rtl/tw_pkg.sv
package tw_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RDAT_ACK,
    ST_SKIP
  } tw_state_t;

  localparam logic [3:0] DEV_TYPE = 4'b0101;

  // address byte: type nibble in [7:4], strap nibble in [3:0]
  function automatic logic addr_match(input logic [7:0] b, input logic [3:0] strap);
    return (b[7:4] == DEV_TYPE) && (b[3:0] == strap);
  endfunction

  // opcodes that return a byte to the host
  function automatic logic is_read_op(input logic [7:0] c);
    return (c[7:4] == 4'b1001) || (c[7:4] == 4'b1011);
  endfunction

  // majority over the low n bits of a window
  function automatic logic vote(input logic [7:0] w, input int n);
    int ones;
    ones = 0;
    for (int i = 0; i < 8; i++) begin
      if (i < n && w[i]) ones++;
    end
    return (2 * ones) > n;
  endfunction

endpackage

// File: rtl/tw_glitch_filter.sv
module tw_glitch_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int TAPS        = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [TAPS-1:0]        win_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      win_q  <= '1;
      dout   <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      win_q  <= {win_q[TAPS-2:0], sync_q[SYNC_STAGES-1]};
      dout   <= tw_pkg::vote(8'(win_q), TAPS);
    end
  end
endmodule

// File: rtl/tw_cond_detect.sv
module tw_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_evt = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_evt  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/tw_frame_core.sv
module tw_frame_core
  import tw_pkg::*;
#(
  parameter int BYTE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_rise,
  input  logic                 scl_fall,
  input  logic                 start_evt,
  input  logic                 stop_evt,
  input  logic                 sda_f,
  input  logic [3:0]           strap_addr,
  input  logic                 nv_busy,
  input  logic [BYTE_BITS-1:0] rd_data,
  output logic                 sda_oe,
  output logic                 cmd_valid,
  output logic [BYTE_BITS-1:0] cmd_byte,
  output logic                 data_valid,
  output logic [BYTE_BITS-1:0] data_byte,
  output logic                 rd_done,
  output logic                 rd_acked,
  output logic                 txn_end,
  output logic                 addr_hit,
  output logic                 bus_idle
);
  localparam int CW = $clog2(BYTE_BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(BYTE_BITS);

  tw_state_t            state;
  logic [CW-1:0]        cnt;
  logic [BYTE_BITS-1:0] sh;
  logic [BYTE_BITS-1:0] tx;
  logic                 rd_mode;
  logic                 sel;
  logic                 byte_end;

  assign byte_end = scl_fall && (cnt == LAST);
  assign bus_idle = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      sh         <= '0;
      tx         <= '0;
      rd_mode    <= 1'b0;
      sel        <= 1'b0;
      sda_oe     <= 1'b0;
      cmd_valid  <= 1'b0;
      cmd_byte   <= '0;
      data_valid <= 1'b0;
      data_byte  <= '0;
      rd_done    <= 1'b0;
      rd_acked   <= 1'b0;
      txn_end    <= 1'b0;
      addr_hit   <= 1'b0;
    end else begin
      cmd_valid  <= 1'b0;
      data_valid <= 1'b0;
      rd_done    <= 1'b0;
      txn_end    <= 1'b0;
      addr_hit   <= 1'b0;
      if (start_evt) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
        sel    <= 1'b0;
      end else if (stop_evt) begin
        state   <= ST_IDLE;
        cnt     <= '0;
        sda_oe  <= 1'b0;
        txn_end <= sel;
        sel     <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_CMD, ST_WDAT: begin
            if (scl_rise) begin
              sh  <= {sh[BYTE_BITS-2:0], sda_f};
              cnt <= cnt + 1'b1;
            end else if (byte_end) begin
              cnt <= '0;
              if (state == ST_ADDR) begin
                if (addr_match(sh, strap_addr) && !nv_busy) begin
                  sda_oe   <= 1'b1;
                  sel      <= 1'b1;
                  addr_hit <= 1'b1;
                  state    <= ST_ADDR_ACK;
                end else begin
                  state <= ST_SKIP;
                end
              end else if (state == ST_CMD) begin
                cmd_byte  <= sh;
                cmd_valid <= 1'b1;
                rd_mode   <= is_read_op(sh);
                sda_oe    <= 1'b1;
                state     <= ST_CMD_ACK;
              end else begin
                data_byte  <= sh;
                data_valid <= 1'b1;
                sda_oe     <= 1'b1;
                state      <= ST_WDAT_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= ST_CMD;
            end
          end
          ST_CMD_ACK: begin
            if (scl_fall) begin
              if (rd_mode) begin
                tx     <= rd_data;
                sda_oe <= ~rd_data[BYTE_BITS-1];
                state  <= ST_RDAT;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_WDAT;
              end
            end
          end
          ST_WDAT_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= ST_SKIP;
            end
          end
          ST_RDAT: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (byte_end) begin
              cnt    <= '0;
              sda_oe <= 1'b0;
              state  <= ST_RDAT_ACK;
            end else if (scl_fall) begin
              tx     <= {tx[BYTE_BITS-2:0], 1'b0};
              sda_oe <= ~tx[BYTE_BITS-2];
            end
          end
          ST_RDAT_ACK: begin
            if (scl_rise) begin
              rd_acked <= ~sda_f;
              rd_done  <= 1'b1;
              state    <= ST_SKIP;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tw_slave_fe.sv
module tw_slave_fe #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 3,
  parameter int BYTE_BITS   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_oe,
  input  logic [3:0]           strap_addr,
  input  logic                 nv_busy,
  input  logic [BYTE_BITS-1:0] rd_data,
  output logic                 cmd_valid,
  output logic [BYTE_BITS-1:0] cmd_byte,
  output logic                 data_valid,
  output logic [BYTE_BITS-1:0] data_byte,
  output logic                 rd_done,
  output logic                 rd_acked,
  output logic                 txn_end
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw_in;
  logic [LINES-1:0] filt;
  logic scl_f, sda_f;
  logic scl_rise, scl_fall, start_evt, stop_evt;
  logic addr_hit, bus_idle;

  assign raw_in = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_filt
    tw_glitch_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .TAPS       (FILT_TAPS)
    ) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_in[g]),
      .dout (filt[g])
    );
  end

  assign scl_f = filt[0];
  assign sda_f = filt[1];

  tw_cond_detect u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_f),
    .sda_f    (sda_f),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt)
  );

  tw_frame_core #(.BYTE_BITS(BYTE_BITS)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .sda_f     (sda_f),
    .strap_addr(strap_addr),
    .nv_busy   (nv_busy),
    .rd_data   (rd_data),
    .sda_oe    (sda_oe),
    .cmd_valid (cmd_valid),
    .cmd_byte  (cmd_byte),
    .data_valid(data_valid),
    .data_byte (data_byte),
    .rd_done   (rd_done),
    .rd_acked  (rd_acked),
    .txn_end   (txn_end),
    .addr_hit  (addr_hit),
    .bus_idle  (bus_idle)
  );
endmodule

// File: rtl/tw_slave_fe_chk.sv
module tw_slave_fe_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_f,
  input logic start_evt,
  input logic sda_oe,
  input logic nv_busy,
  input logic addr_hit,
  input logic bus_idle,
  input logic cmd_valid,
  input logic data_valid,
  input logic txn_end
);
  // R4
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_f));

  // R8
  busy_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit |-> !$past(nv_busy));

  // R1
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_oe);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_idle |-> !sda_oe);

  // R9
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_valid, data_valid, txn_end}));
endmodule

bind tw_slave_fe tw_slave_fe_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_f     (scl_f),
  .start_evt (start_evt),
  .sda_oe    (sda_oe),
  .nv_busy   (nv_busy),
  .addr_hit  (addr_hit),
  .bus_idle  (bus_idle),
  .cmd_valid (cmd_valid),
  .data_valid(data_valid),
  .txn_end   (txn_end)
);

// File: tb/tw_slave_fe_tb.sv
module tw_slave_fe_tb;
  localparam int Q = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, scl, m_low, nv_busy;
  logic [3:0] strap;
  logic [7:0] rd_data;
  logic       sda_oe, cmd_valid, data_valid, rd_done, rd_acked, txn_end;
  logic [7:0] cmd_byte, data_byte;
  wire        sda_bus = !(m_low || sda_oe);

  tw_slave_fe u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .strap_addr(strap), .nv_busy(nv_busy), .rd_data(rd_data),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .data_valid(data_valid),
    .data_byte(data_byte), .rd_done(rd_done), .rd_acked(rd_acked), .txn_end(txn_end)
  );

  int n_chk = 0, n_fail = 0;
  int n_cmd, n_dat, n_end, n_rd;
  logic [7:0] last_cmd, last_dat;
  logic last_rdack;
  bit done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      n_cmd <= 0; n_dat <= 0; n_end <= 0; n_rd <= 0;
      last_cmd <= 8'h00; last_dat <= 8'h00; last_rdack <= 1'b0;
    end else begin
      if (cmd_valid)  begin n_cmd <= n_cmd + 1; last_cmd <= cmd_byte; end
      if (data_valid) begin n_dat <= n_dat + 1; last_dat <= data_byte; end
      if (txn_end)    n_end <= n_end + 1;
      if (rd_done)    begin n_rd <= n_rd + 1; last_rdack <= rd_acked; end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    m_low = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    m_low = 1'b1; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic do_stop();
    m_low = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    m_low = 1'b0; tick(2 * Q);
  endtask

  task automatic send_bit(input logic b, input bit glitch);
    m_low = !b; tick(Q);
    scl = 1'b1; tick(Q);
    if (glitch) begin
      scl = 1'b0; tick(1);
      scl = 1'b1; tick(Q - 1);
    end else tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic recv_bit(output logic b);
    m_low = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    b = sda_bus;  tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, input bit glitch, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i], glitch);
    recv_bit(b);
    ack = !b;
  endtask

  task automatic recv_byte(output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      v[i] = b;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual %0h expected %0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] rb;
    int base_end, base_cmd;
    rst_n = 1'b0; scl = 1'b1; m_low = 1'b0; nv_busy = 1'b0;
    strap = 4'hA; rd_data = 8'h00;
    tick(10);
    check("R4 reset sda_oe", int'(sda_oe), 0);
    rst_n = 1'b1;
    tick(20);

    // R2: clocking with no start
    scl = 1'b0; tick(Q);
    send_byte(8'h5A, 1'b0, ack);
    check("R2 no ack before start", int'(ack), 0);
    check("R2 no cmd before start", n_cmd, 0);
    m_low = 1'b0; tick(Q); scl = 1'b1; tick(2 * Q);

    // R3: full address sweep
    for (int a = 0; a < 256; a++) begin
      logic [7:0] av;
      int exp_ack;
      av = 8'(a);
      exp_ack = (av[7:4] == 4'b0101 && av[3:0] == strap) ? 1 : 0;
      do_start();
      send_byte(av, 1'b0, ack);
      do_stop();
      check($sformatf("R3 addr %02h", a), int'(ack), exp_ack);
    end
    // R9: only the matching address ended an addressed transaction
    check("R9 txn_end after sweep", n_end, 1);

    // R3: other strap value
    strap = 4'h3;
    do_start(); send_byte(8'h53, 1'b0, ack); do_stop();
    check("R3 strap 3 match", int'(ack), 1);
    do_start(); send_byte(8'h5A, 1'b0, ack); do_stop();
    check("R3 strap 3 old addr", int'(ack), 0);
    strap = 4'hA;

    // R3: silent after mismatch
    base_cmd = n_cmd;
    do_start(); send_byte(8'h5B, 1'b0, ack);
    send_byte(8'hA4, 1'b0, ack);
    check("R3 ignored after mismatch ack", int'(ack), 0);
    do_stop();
    check("R3 ignored after mismatch cmd", n_cmd, base_cmd);

    // R5 / R6: write transaction
    base_end = n_end;
    do_start(); send_byte(8'h5A, 1'b0, ack);
    send_byte(8'hA4, 1'b0, ack);
    check("R5 cmd ack", int'(ack), 1);
    tick(2);
    check("R5 cmd byte", int'(last_cmd), 'hA4);
    tick(Q);
    check("R4 released after ack", int'(sda_oe), 0);
    send_byte(8'h2A, 1'b0, ack);
    check("R6 data ack", int'(ack), 1);
    check("R6 data byte", int'(last_dat), 'h2A);
    send_byte(8'h11, 1'b0, ack);
    check("R6 trailing byte nack", int'(ack), 0);
    do_stop();
    check("R9 txn_end after write", n_end, base_end + 1);

    // R6: second write opcode and pattern
    do_start(); send_byte(8'h5A, 1'b0, ack);
    send_byte(8'hC6, 1'b0, ack);
    send_byte(8'h15, 1'b0, ack);
    check("R6 data byte 2", int'(last_dat), 'h15);
    do_stop();

    // R7: read, master NACK
    rd_data = 8'hB5;
    do_start(); send_byte(8'h5A, 1'b0, ack);
    send_byte(8'h96, 1'b0, ack);
    check("R7 read cmd ack", int'(ack), 1);
    recv_byte(rb);
    check("R7 read byte 1", int'(rb), 'hB5);
    send_bit(1'b1, 1'b0);
    check("R7 rd_done count 1", n_rd, 1);
    check("R7 master nack", int'(last_rdack), 0);
    do_stop();

    // R7: second read opcode, master ACK
    rd_data = 8'h3C;
    do_start(); send_byte(8'h5A, 1'b0, ack);
    send_byte(8'hB8, 1'b0, ack);
    recv_byte(rb);
    check("R7 read byte 2", int'(rb), 'h3C);
    send_bit(1'b0, 1'b0);
    check("R7 master ack", int'(last_rdack), 1);
    do_stop();

    // R8: busy poll
    base_end = n_end;
    nv_busy = 1'b1;
    do_start(); send_byte(8'h5A, 1'b0, ack); do_stop();
    check("R8 busy nack", int'(ack), 0);
    check("R9 no txn_end when refused", n_end, base_end);
    nv_busy = 1'b0;
    do_start(); send_byte(8'h5A, 1'b0, ack); do_stop();
    check("R8 ack after busy", int'(ack), 1);

    // R1: repeated start in mid-command
    do_start(); send_byte(8'h5A, 1'b0, ack);
    for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0);
    do_start();
    send_byte(8'h5A, 1'b0, ack);
    check("R1 restart addr ack", int'(ack), 1);
    send_byte(8'hA1, 1'b0, ack);
    check("R1 cmd after restart", int'(last_cmd), 'hA1);
    do_stop();
    tick(2);
    check("R1 idle after stop", int'(sda_oe), 0);

    // R10: SCL glitches in every bit
    do_start(); send_byte(8'h5A, 1'b1, ack);
    check("R10 glitched addr ack", int'(ack), 1);
    send_byte(8'hA7, 1'b1, ack);
    check("R10 glitched cmd byte", int'(last_cmd), 'hA7);
    do_stop();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule